// File: doc/BRIEF.md
# Instruction Byte-Stream Parser

This block sits between an instruction fetch stage and the decode/execute logic. It accepts instruction bytes one per handshake on a valid/ready byte port. From those bytes it builds one complete, variable-length instruction record at a time. Every instruction opens with a two-byte control word, sent low byte first. The parser reads the opcode, the operation size and the two operand type fields from that word. From them it works out how many source bytes and how many target bytes follow, collects those bytes, and then presents the finished record on a valid/ready output port.

The record carries the opcode, size, condition code, both operand types and both operand values. Each value is zero-extended to 32 bits. The record also carries two derived signals. The first tells whether the condition code passes against the zero and carry flags currently driven into the block. The second marks the instruction as illegal when the encoding is reserved or undefined. The parser does not fetch memory, execute operations or change any flags.

Top module: `insn_byte_parser`

## Requirements
- R1: The first accepted byte is the low half of the control word and the second is the high half. In that 16-bit word, bits 1:0 are the source type and bits 3:2 are the target type. Bits 6:4 are the condition, bit 7 is reserved, bits 13:8 are the opcode and bits 15:14 are the size (0 = 8 bits, 1 = 16 bits, 2 = 32 bits).
- R2: The opcode decides which operands are present. Opcodes 0x00, 0x0C, 0x0D, 0x10, 0x1C, 0x1D, 0x20, 0x2A and 0x3A have no operand. Opcodes 0x08, 0x09, 0x0A, 0x11, 0x18, 0x19, 0x1A, 0x28, 0x29, 0x2C, 0x2D, 0x31, 0x33 and 0x3D have a source only. Opcodes 0x01 to 0x07, 0x0B, 0x13 to 0x17, 0x1B, 0x21 to 0x27, 0x32, 0x34, 0x35 and 0x39 have a source and a target. Any other opcode has no operand. An absent operand reads as zero.
- R3: An operand of type 0 (register) or type 1 (register pointer) takes 1 byte. An operand of type 3 (immediate pointer) takes 4 bytes. An operand of type 2 (immediate) takes as many bytes as the size field gives, and size 3 takes 4 bytes.
- R4: For opcodes 0x04, 0x05, 0x06, 0x15, 0x16, 0x24, 0x25 and 0x26, a source immediate is always 1 byte. A target immediate on these opcodes still follows R3.
- R5: All source bytes arrive before all target bytes. A multi-byte value is assembled lowest byte first and zero-extended to 32 bits.
- R6: The condition-pass output uses the live flags Z and C. Code 0 always passes, 1 passes when Z is set, 2 when Z is clear, 3 when C is set and 4 when C is clear. Code 5 passes when both flags are clear, code 6 passes when either flag is set, and code 7 never passes.
- R7: The record is flagged illegal if the opcode is outside the R2 set, if the size is 3, if reserved bit 7 is set, or if the condition is 7.
- R8: The record is flagged illegal if a present register or register-pointer operand holds a number above 34. Numbers 0 to 34 are legal.
- R9: A presented record stays valid and unchanged until output ready is high. While it waits, input ready is low and no byte is consumed. The cycle after the output handshake, the parser accepts bytes again.
- R10: After reset, output valid is low and input ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction byte available |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser takes a byte this cycle |
| flag_z | input | 1 | Zero flag for the condition check |
| flag_c | input | 1 | Carry flag for the condition check |
| out_valid | output | 1 | Decoded record available |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 6 | Opcode field |
| out_size | output | 2 | Size field |
| out_cond | output | 3 | Condition field |
| out_src_type | output | 2 | Source operand type |
| out_tgt_type | output | 2 | Target operand type |
| out_src_val | output | 32 | Source operand value, zero-extended |
| out_tgt_val | output | 32 | Target operand value, zero-extended |
| out_cond_pass | output | 1 | Condition holds for the current flags |
| out_illegal | output | 1 | Encoding is reserved or undefined |

## Verification
The assertions check the output handshake on every cycle. A waiting record must stay unchanged. A record may appear only just after a byte was accepted. The parser must take input again right after the record leaves. Size 3 must be flagged illegal, and condition 7 must never pass. The byte counts per opcode, operand type and size, the little-endian assembly, the short shift immediate, the full condition table and the register-number limit can only be shown by the bench's directed byte streams.

// File: rtl/insn_byte_parser.sv
module insn_byte_parser #(
  parameter int REG_MAX = 34
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  input  logic        flag_z,
  input  logic        flag_c,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [5:0]  out_opcode,
  output logic [1:0]  out_size,
  output logic [2:0]  out_cond,
  output logic [1:0]  out_src_type,
  output logic [1:0]  out_tgt_type,
  output logic [31:0] out_src_val,
  output logic [31:0] out_tgt_val,
  output logic        out_cond_pass,
  output logic        out_illegal
);

  typedef enum logic [2:0] {S_LO, S_HI, S_SRC, S_TGT, S_OUT} state_t;

  state_t      state;
  logic [15:0] cw;
  logic [2:0]  src_len, tgt_len;
  logic [1:0]  idx;

  // operand class: 0 none, 1 source only, 2 source and target, 3 undefined
  function automatic logic [1:0] op_class(input logic [5:0] op);
    case (op)
      6'h00, 6'h0C, 6'h0D, 6'h10, 6'h1C, 6'h1D, 6'h20, 6'h2A, 6'h3A: op_class = 2'd0;
      6'h08, 6'h09, 6'h0A, 6'h11, 6'h18, 6'h19, 6'h1A, 6'h28, 6'h29,
      6'h2C, 6'h2D, 6'h31, 6'h33, 6'h3D:                            op_class = 2'd1;
      6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h0B,
      6'h13, 6'h14, 6'h15, 6'h16, 6'h17, 6'h1B,
      6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
      6'h32, 6'h34, 6'h35, 6'h39:                                   op_class = 2'd2;
      default:                                                      op_class = 2'd3;
    endcase
  endfunction

  function automatic logic short_imm(input logic [5:0] op);
    case (op)
      6'h04, 6'h05, 6'h06, 6'h15, 6'h16, 6'h24, 6'h25, 6'h26: short_imm = 1'b1;
      default:                                                short_imm = 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] opnd_len(input logic [1:0] typ, input logic [1:0] sz,
                                          input logic one_byte);
    case (typ)
      2'd0, 2'd1: opnd_len = 3'd1;
      2'd2:       opnd_len = one_byte ? 3'd1 : (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
      default:    opnd_len = 3'd4;
    endcase
  endfunction

  wire [15:0] cw_next  = {in_byte, cw[7:0]};
  wire [1:0]  cls_next = op_class(cw_next[13:8]);
  wire        has_src_next = (cls_next == 2'd1) || (cls_next == 2'd2);
  wire        has_tgt_next = (cls_next == 2'd2);
  wire [2:0]  src_len_next = has_src_next ?
                opnd_len(cw_next[1:0], cw_next[15:14], short_imm(cw_next[13:8])) : 3'd0;
  wire [2:0]  tgt_len_next = has_tgt_next ? opnd_len(cw_next[3:2], cw_next[15:14], 1'b0) : 3'd0;

  wire take = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_LO;
      cw          <= '0;
      src_len     <= '0;
      tgt_len     <= '0;
      idx         <= '0;
      out_src_val <= '0;
      out_tgt_val <= '0;
    end else begin
      case (state)
        S_LO: if (take) begin
          cw[7:0]     <= in_byte;
          out_src_val <= '0;
          out_tgt_val <= '0;
          state       <= S_HI;
        end
        S_HI: if (take) begin
          cw[15:8] <= in_byte;
          src_len  <= src_len_next;
          tgt_len  <= tgt_len_next;
          idx      <= '0;
          state    <= (src_len_next != 3'd0) ? S_SRC :
                      (tgt_len_next != 3'd0) ? S_TGT : S_OUT;
        end
        S_SRC: if (take) begin
          out_src_val[{idx, 3'b000} +: 8] <= in_byte;
          if ({1'b0, idx} == src_len - 3'd1) begin
            idx   <= '0;
            state <= (tgt_len != 3'd0) ? S_TGT : S_OUT;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_TGT: if (take) begin
          out_tgt_val[{idx, 3'b000} +: 8] <= in_byte;
          if ({1'b0, idx} == tgt_len - 3'd1) begin
            idx   <= '0;
            state <= S_OUT;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        default: if (out_ready) state <= S_LO;
      endcase
    end
  end

  assign in_ready     = (state != S_OUT);
  assign out_valid    = (state == S_OUT);
  assign out_opcode   = cw[13:8];
  assign out_size     = cw[15:14];
  assign out_cond     = cw[6:4];
  assign out_src_type = cw[1:0];
  assign out_tgt_type = cw[3:2];

  always_comb begin
    case (out_cond)
      3'd0:    out_cond_pass = 1'b1;
      3'd1:    out_cond_pass = flag_z;
      3'd2:    out_cond_pass = !flag_z;
      3'd3:    out_cond_pass = flag_c;
      3'd4:    out_cond_pass = !flag_c;
      3'd5:    out_cond_pass = !flag_z && !flag_c;
      3'd6:    out_cond_pass = flag_z || flag_c;
      default: out_cond_pass = 1'b0;
    endcase
  end

  wire [1:0] cls     = op_class(out_opcode);
  wire       src_reg = (cls == 2'd1 || cls == 2'd2) && !out_src_type[1];
  wire       tgt_reg = (cls == 2'd2) && !out_tgt_type[1];
  wire       bad_reg = (src_reg && out_src_val > REG_MAX) || (tgt_reg && out_tgt_val > REG_MAX);

  assign out_illegal = (cls == 2'd3) || (out_size == 2'd3) || cw[7] ||
                       (out_cond == 3'd7) || bad_reg;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_opcode, out_size, out_cond, out_src_type, out_tgt_type, out_src_val, out_tgt_val}));

  assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);

  assert_record_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_size3_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_size == 2'd3 |-> out_illegal);

  assert_cond7_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cond == 3'd7 |-> !out_cond_pass && out_illegal);

endmodule

// File: tb/test_insn_byte_parser.sv
`timescale 1ns/100ps
module test_insn_byte_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_ready;
  logic        flag_z = 1'b0;
  logic        flag_c = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [5:0]  out_opcode;
  logic [1:0]  out_size;
  logic [2:0]  out_cond;
  logic [1:0]  out_src_type, out_tgt_type;
  logic [31:0] out_src_val, out_tgt_val;
  logic        out_cond_pass, out_illegal;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  insn_byte_parser i_insn_byte_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .flag_z(flag_z), .flag_c(flag_c), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_size(out_size), .out_cond(out_cond),
    .out_src_type(out_src_type), .out_tgt_type(out_tgt_type),
    .out_src_val(out_src_val), .out_tgt_val(out_tgt_val),
    .out_cond_pass(out_cond_pass), .out_illegal(out_illegal));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_cw(input logic [15:0] w);
    send(w[7:0]);
    send(w[15:8]);
  endtask

  task automatic expect_rec(input string tag, input logic [5:0] op, input logic [1:0] sz,
                            input logic [2:0] cd, input logic [1:0] st, input logic [1:0] tt,
                            input logic [31:0] sv, input logic [31:0] tv, input logic ill);
    chk({tag, " out_valid"}, out_valid, 1);
    chk({tag, " opcode"}, out_opcode, op);
    chk({tag, " size"}, out_size, sz);
    chk({tag, " cond"}, out_cond, cd);
    chk({tag, " src_type"}, out_src_type, st);
    chk({tag, " tgt_type"}, out_tgt_type, tt);
    chk({tag, " src_val"}, out_src_val, sv);
    chk({tag, " tgt_val"}, out_tgt_val, tv);
    chk({tag, " illegal"}, out_illegal, ill);
  endtask

  task automatic accept();
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 out_valid after reset", out_valid, 0);
    chk("R10 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_no_operand();
    send_cw(16'h0000);
    expect_rec("R2 nop", 6'h00, 2'd0, 3'd0, 2'd0, 2'd0, 0, 0, 0);
    chk("R6 cond 0 passes", out_cond_pass, 1);
    accept();
  endtask

  task automatic t_reg_reg();
    send_cw(16'h8100);
    send(8'd5);
    chk("R3 not done after 1 of 2 register bytes", out_valid, 0);
    send(8'd7);
    expect_rec("R1 R3 add reg,reg", 6'h01, 2'd2, 3'd0, 2'd0, 2'd0, 5, 7, 0);
    accept();
  endtask

  task automatic t_imm16();
    send_cw(16'h5702);
    send(8'h34);
    send(8'h12);
    chk("R3 imm16 then target pending", out_valid, 0);
    send(8'h09);
    expect_rec("R5 mov imm16", 6'h17, 2'd1, 3'd0, 2'd2, 2'd0, 32'h1234, 9, 0);
    accept();
  endtask

  task automatic t_short_imm();
    send_cw(16'h8402);
    send(8'h03);
    chk("R4 short imm one byte, target pending", out_valid, 0);
    send(8'h04);
    expect_rec("R4 sla short imm", 6'h04, 2'd2, 3'd0, 2'd2, 2'd0, 3, 4, 0);
    accept();
  endtask

  task automatic t_wide();
    send_cw(16'h870B);
    send(8'h78); send(8'h56); send(8'h34); send(8'h12);
    send(8'hEF); send(8'hBE); send(8'hAD);
    chk("R3 imm32 target needs 4 bytes", out_valid, 0);
    send(8'hDE);
    expect_rec("R5 cmp ptr,imm32", 6'h07, 2'd2, 3'd0, 2'd3, 2'd2, 32'h12345678, 32'hDEADBEEF, 0);
    accept();
  endtask

  task automatic t_src_only();
    flag_z = 1'b1;
    send_cw(16'h8812);
    send(8'h44); send(8'h33); send(8'h22); send(8'h11);
    expect_rec("R2 jmp source only", 6'h08, 2'd2, 3'd1, 2'd2, 2'd0, 32'h11223344, 0, 0);
    chk("R6 ifz with Z set", out_cond_pass, 1);
    flag_z = 1'b0;
    #1;
    chk("R6 ifz with Z clear", out_cond_pass, 0);
    accept();
  endtask

  task automatic t_cond_table();
    for (int c = 0; c < 8; c++) begin
      send_cw(16'(c << 4));
      chk("R7 cond 7 illegal", out_illegal, (c == 7) ? 1 : 0);
      for (int f = 0; f < 4; f++) begin
        logic z, cy, e;
        z = f[0]; cy = f[1];
        flag_z = z; flag_c = cy;
        #1;
        case (c)
          0: e = 1;
          1: e = z;
          2: e = !z;
          3: e = cy;
          4: e = !cy;
          5: e = !z && !cy;
          6: e = z || cy;
          default: e = 0;
        endcase
        chk($sformatf("R6 cond %0d z=%0d c=%0d", c, z, cy), out_cond_pass, e);
      end
      accept();
    end
    flag_z = 1'b0; flag_c = 1'b0;
  endtask

  task automatic t_illegal();
    send_cw(16'hD702);
    send(8'h01); send(8'h02); send(8'h03);
    chk("R3 size 3 imm is 4 bytes", out_valid, 0);
    send(8'h04); send(8'h02);
    expect_rec("R7 size 3", 6'h17, 2'd3, 3'd0, 2'd2, 2'd0, 32'h04030201, 2, 1);
    accept();
    send_cw(16'h0080);
    expect_rec("R7 reserved bit", 6'h00, 2'd0, 3'd0, 2'd0, 2'd0, 0, 0, 1);
    accept();
    send_cw(16'h0E00);
    expect_rec("R7 undefined opcode no operands", 6'h0E, 2'd0, 3'd0, 2'd0, 2'd0, 0, 0, 1);
    accept();
  endtask

  task automatic t_reg_range();
    send_cw(16'h8100);
    send(8'd35); send(8'd1);
    chk("R8 source register 35 illegal", out_illegal, 1);
    accept();
    send_cw(16'h8104);
    send(8'd34); send(8'd40);
    chk("R8 target register pointer 40 illegal", out_illegal, 1);
    accept();
    send_cw(16'h8100);
    send(8'd34); send(8'd33);
    chk("R8 registers 34 and 33 legal", out_illegal, 0);
    accept();
  endtask

  task automatic t_hold();
    send_cw(16'h9702);
    send(8'hAA); send(8'hBB); send(8'hCC); send(8'hDD); send(8'd3);
    in_valid = 1'b1;
    in_byte  = 8'hFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 held valid", out_valid, 1);
      chk("R9 input stalled", in_ready, 0);
      chk("R9 src stable", out_src_val, 32'hDDCCBBAA);
    end
    in_valid = 1'b0;
    accept();
    chk("R9 ready after handshake", in_ready, 1);
    send_cw(16'h1000);
    expect_rec("R9 no byte consumed while held", 6'h10, 2'd0, 3'd0, 2'd0, 2'd0, 0, 0, 0);
    accept();
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_operand();
    t_reg_reg();
    t_imm16();
    t_short_imm();
    t_wide();
    t_src_only();
    t_cond_table();
    t_illegal();
    t_reg_range();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule